// File: doc/BRIEF.md
# Nap-Mode Power Controller

This block sequences a processor core into and out of a low-power nap state. Software requests nap by writing the power-save control bit. The controller then stops instruction dispatch. It waits until the core pipeline and every bus activity source are quiet, and only then removes the registered clock enable of the gated core domain. A HALTED status output tells the system that the core is idle.

While the core naps, the system may raise a RUN request so that the gated clocks restart and bus snoops can be serviced. Execution does not resume during this time. HALTED falls while bus activity such as a snoop pushout is under way. It rises again when the bus is idle, which tells the system that RUN may be dropped. The clock then stops once more. An enabled interrupt from any wake source ends the nap: the clock enable is restored, the power-save bit is cleared and a one-cycle wake pulse goes to the exception logic. The controller itself, the wake logic and the timer sources are in the always-clocked domain.

Top module: `nap_power_ctrl`

## Requirements
- R1: After reset, core_clk_en is 1, and halted, msr_pow, dispatch_stop and wake_pulse are all 0.
- R2: A pow_set pulse sampled while running sets msr_pow and dispatch_stop from the next cycle. core_clk_en stays 1 and halted stays 0 at that point.
- R3: While draining, core_clk_en stays 1 and halted stays 0 as long as core_busy or any bus_busy bit is 1. At the first edge where all are 0 (with RUN not seen and no wake), core_clk_en goes to 0 and halted goes to 1 after that same edge.
- R4: If run_req is sampled high on three consecutive clock edges, core_clk_en is 1 after the third edge. While napping, dispatch_stop and msr_pow stay 1.
- R5: While the clock runs in nap because of RUN, halted goes to 0 one cycle after any activity input is sampled high. It returns to 1 one cycle after all activity inputs are sampled low.
- R6: The nap clock is removed again only when RUN, seen through its two-stage synchronizer, is low and halted is already 1. If run_req falls while the bus is idle, core_clk_en is 0 after the third edge.
- R7: In nap, if ee_enable is 1 and any wake_src bit is 1 at an edge, then after that edge core_clk_en is 1, halted, msr_pow and dispatch_stop are 0, and wake_pulse is 1 for exactly one cycle.
- R8: With ee_enable at 0, wake_src has no effect. The core stays napped with core_clk_en 0, halted 1 and wake_pulse 0.
- R9: When a wake and a RUN request arrive in the same cycle, the wake wins: the core returns to running, and a RUN that stays high afterwards does not stop dispatch.
- R10: A wake request seen during draining has no effect while activity remains. When the core becomes quiet, the controller returns to running with a wake pulse instead of entering nap.
- R11: If RUN is already seen when draining completes, the controller enters nap with the clock still enabled and halted at 1.
- R12: While running, wake_src with ee_enable set produces no wake_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, always running |
| rst_n | input | 1 | Active-low synchronous reset |
| pow_set | input | 1 | One-cycle write that sets the power-save bit |
| ee_enable | input | 1 | External interrupt enable; gates every wake source |
| wake_src | input | N_WAKE_SRC | Interrupt requests that can wake the core (external, decrementer) |
| core_busy | input | 1 | Instructions still in flight in the core |
| bus_busy | input | N_BUS_SRC | Active, queued or snoop-pushout bus transactions |
| run_req | input | 1 | System request to run clocks for snooping |
| msr_pow | output | 1 | Current value of the power-save bit |
| dispatch_stop | output | 1 | Holds instruction dispatch off |
| core_clk_en | output | 1 | Registered enable for the gated core clock |
| halted | output | 1 | Core idle in nap |
| wake_pulse | output | 1 | One-cycle wake indication to exception logic |

## Verification
Two things can happen in the same cycle: a wake interrupt and a RUN request, both while napping with the clock stopped. A second pair is a wake request and drain completion. The bench raises each pair on the same falling edge. The first pair must return the core to running with a single wake pulse and no stall from the lingering RUN. For the second pair, the wake must be held off while core_busy stays high and then taken in place of nap when the core is quiet. Because the outputs are registered and RUN passes through a synchronizer, every expected value is counted out edge by edge from the requirements.

// File: rtl/nap_pkg.sv
package nap_pkg;

    typedef enum logic [1:0] {
        ST_RUNNING = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_SNOOP   = 2'd3
    } nap_state_e;

    typedef struct packed {
        nap_state_e state;
        logic       pow;
        logic       clk_en;
        logic       halted;
        logic       wake;
    } nap_regs_t;

    localparam nap_regs_t NAP_RESET = '{
        state:  ST_RUNNING,
        pow:    1'b0,
        clk_en: 1'b1,
        halted: 1'b0,
        wake:   1'b0
    };

endpackage

// File: rtl/nap_run_sync.sv
module nap_run_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    output logic req_sync
);

    logic [STAGES-1:0] shift_q;
    logic [STAGES-1:0] shift_d;

    generate
        if (STAGES == 1) begin : g_single
            assign shift_d = req_in;
        end else begin : g_chain
            assign shift_d = {shift_q[STAGES-2:0], req_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= shift_d;
        end
    end

    assign req_sync = shift_q[STAGES-1];

endmodule

// File: rtl/nap_quiet_detect.sv
module nap_quiet_detect #(
    parameter int N_BUS_SRC = 3
) (
    input  logic                 core_busy,
    input  logic [N_BUS_SRC-1:0] bus_busy,
    output logic                 quiet
);

    always_comb begin
        quiet = !core_busy;
        for (int i = 0; i < N_BUS_SRC; i++) begin
            if (bus_busy[i]) begin
                quiet = 1'b0;
            end
        end
    end

endmodule

// File: rtl/nap_wake_gate.sv
module nap_wake_gate #(
    parameter int N_WAKE_SRC = 2
) (
    input  logic                  ee_enable,
    input  logic [N_WAKE_SRC-1:0] wake_src,
    output logic                  wake_req
);

    always_comb begin
        wake_req = 1'b0;
        for (int i = 0; i < N_WAKE_SRC; i++) begin
            if (wake_src[i] && ee_enable) begin
                wake_req = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nap_power_ctrl.sv
module nap_power_ctrl
    import nap_pkg::*;
#(
    parameter int N_WAKE_SRC      = 2,
    parameter int N_BUS_SRC       = 3,
    parameter int RUN_SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pow_set,
    input  logic                  ee_enable,
    input  logic [N_WAKE_SRC-1:0] wake_src,
    input  logic                  core_busy,
    input  logic [N_BUS_SRC-1:0]  bus_busy,
    input  logic                  run_req,
    output logic                  msr_pow,
    output logic                  dispatch_stop,
    output logic                  core_clk_en,
    output logic                  halted,
    output logic                  wake_pulse
);

    nap_regs_t regs_d;
    nap_regs_t regs_q;
    logic      run_seen;
    logic      quiet;
    logic      wake_req;

    nap_run_sync #(
        .STAGES (RUN_SYNC_STAGES)
    ) u_run_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (run_req),
        .req_sync (run_seen)
    );

    nap_quiet_detect #(
        .N_BUS_SRC (N_BUS_SRC)
    ) u_quiet (
        .core_busy (core_busy),
        .bus_busy  (bus_busy),
        .quiet     (quiet)
    );

    nap_wake_gate #(
        .N_WAKE_SRC (N_WAKE_SRC)
    ) u_wake (
        .ee_enable (ee_enable),
        .wake_src  (wake_src),
        .wake_req  (wake_req)
    );

    // Next-state logic: wake has priority over RUN in every nap state.
    always_comb begin
        regs_d      = regs_q;
        regs_d.wake = 1'b0;
        unique case (regs_q.state)
            ST_RUNNING: begin
                regs_d.clk_en = 1'b1;
                regs_d.halted = 1'b0;
                if (pow_set) begin
                    regs_d.pow   = 1'b1;
                    regs_d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (quiet) begin
                    if (wake_req) begin
                        regs_d.state  = ST_RUNNING;
                        regs_d.pow    = 1'b0;
                        regs_d.clk_en = 1'b1;
                        regs_d.halted = 1'b0;
                        regs_d.wake   = 1'b1;
                    end else if (run_seen) begin
                        regs_d.state  = ST_SNOOP;
                        regs_d.clk_en = 1'b1;
                        regs_d.halted = 1'b1;
                    end else begin
                        regs_d.state  = ST_SLEEP;
                        regs_d.clk_en = 1'b0;
                        regs_d.halted = 1'b1;
                    end
                end
            end
            ST_SLEEP: begin
                // Gated domain is frozen: activity inputs are not sampled.
                regs_d.halted = 1'b1;
                if (wake_req) begin
                    regs_d.state  = ST_RUNNING;
                    regs_d.pow    = 1'b0;
                    regs_d.clk_en = 1'b1;
                    regs_d.halted = 1'b0;
                    regs_d.wake   = 1'b1;
                end else if (run_seen) begin
                    regs_d.state  = ST_SNOOP;
                    regs_d.clk_en = 1'b1;
                end
            end
            ST_SNOOP: begin
                if (wake_req) begin
                    regs_d.state  = ST_RUNNING;
                    regs_d.pow    = 1'b0;
                    regs_d.clk_en = 1'b1;
                    regs_d.halted = 1'b0;
                    regs_d.wake   = 1'b1;
                end else begin
                    regs_d.halted = quiet;
                    if (!run_seen && regs_q.halted && quiet) begin
                        regs_d.state  = ST_SLEEP;
                        regs_d.clk_en = 1'b0;
                    end
                end
            end
            default: begin
                regs_d = NAP_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= NAP_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign msr_pow       = regs_q.pow;
    assign dispatch_stop = (regs_q.state != ST_RUNNING);
    assign core_clk_en   = regs_q.clk_en;
    assign halted        = regs_q.halted;
    assign wake_pulse    = regs_q.wake;

endmodule

// File: rtl/nap_power_ctrl_chk.sv
module nap_power_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ee_enable,
    input logic run_req,
    input logic msr_pow,
    input logic dispatch_stop,
    input logic core_clk_en,
    input logic halted,
    input logic wake_pulse
);

    logic [1:0] since_rst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 2'd3) begin
            since_rst_q <= since_rst_q + 2'd1;
        end
    end

    // R4: three sampled RUN highs guarantee a running clock
    a_r4_run_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3 && $past(run_req, 3) && $past(run_req, 2) && $past(run_req))
            |-> core_clk_en);

    // R7: wake pulse lasts one cycle
    a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R7: wake pulse coincides with restored running outputs
    a_r7_wake_restores: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (core_clk_en && !halted && !msr_pow && !dispatch_stop));

    // R8: no wake without interrupt enable
    a_r8_wake_needs_ee: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q != 2'd0 && wake_pulse) |-> $past(ee_enable));

    // R3: clock is off only while halted
    a_r3_gated_means_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> halted);

    // R6: clock removal happens only in nap with halted set
    a_r6_stop_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> (halted && dispatch_stop && msr_pow));

    // R2: power-save bit and dispatch stop move together
    a_r2_pow_stops_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        msr_pow == dispatch_stop);

endmodule

bind nap_power_ctrl nap_power_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ee_enable     (ee_enable),
    .run_req       (run_req),
    .msr_pow       (msr_pow),
    .dispatch_stop (dispatch_stop),
    .core_clk_en   (core_clk_en),
    .halted        (halted),
    .wake_pulse    (wake_pulse)
);

// File: tb/nap_power_ctrl_bench.sv
`timescale 1ns/1ps
module nap_power_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pow_set = 1'b0;
    logic       ee_enable = 1'b0;
    logic [1:0] wake_src = '0;
    logic       core_busy = 1'b0;
    logic [2:0] bus_busy = '0;
    logic       run_req = 1'b0;
    logic       msr_pow;
    logic       dispatch_stop;
    logic       core_clk_en;
    logic       halted;
    logic       wake_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nap_power_ctrl u_nap_power_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pow_set       (pow_set),
        .ee_enable     (ee_enable),
        .wake_src      (wake_src),
        .core_busy     (core_busy),
        .bus_busy      (bus_busy),
        .run_req       (run_req),
        .msr_pow       (msr_pow),
        .dispatch_stop (dispatch_stop),
        .core_clk_en   (core_clk_en),
        .halted        (halted),
        .wake_pulse    (wake_pulse)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic enter_quiet_nap();
        pow_set = 1'b1;
        step(1);
        pow_set = 1'b0;
        step(1);
    endtask

    task automatic wake_up();
        ee_enable = 1'b1;
        wake_src  = 2'b01;
        step(1);
        wake_src  = 2'b00;
        step(1);
    endtask

    task automatic t_reset();
        check("R1", "core_clk_en", core_clk_en, 1'b1);
        check("R1", "halted", halted, 1'b0);
        check("R1", "msr_pow", msr_pow, 1'b0);
        check("R1", "dispatch_stop", dispatch_stop, 1'b0);
        check("R1", "wake_pulse", wake_pulse, 1'b0);
    endtask

    task automatic t_entry_busy();
        bus_busy = 3'b010;
        pow_set  = 1'b1;
        step(1);
        pow_set  = 1'b0;
        check("R2", "msr_pow", msr_pow, 1'b1);
        check("R2", "dispatch_stop", dispatch_stop, 1'b1);
        check("R2", "core_clk_en", core_clk_en, 1'b1);
        check("R2", "halted", halted, 1'b0);
        step(3);
        check("R3", "clk_en while busy", core_clk_en, 1'b1);
        check("R3", "halted while busy", halted, 1'b0);
        bus_busy = 3'b000;
        step(1);
        check("R3", "clk_en after quiet", core_clk_en, 1'b0);
        check("R3", "halted after quiet", halted, 1'b1);
        ee_enable = 1'b1;
        wake_src  = 2'b10;
        step(1);
        wake_src  = 2'b00;
        check("R7", "clk_en on wake", core_clk_en, 1'b1);
        check("R7", "halted on wake", halted, 1'b0);
        check("R7", "msr_pow on wake", msr_pow, 1'b0);
        check("R7", "dispatch_stop on wake", dispatch_stop, 1'b0);
        check("R7", "wake_pulse", wake_pulse, 1'b1);
        step(1);
        check("R7", "wake_pulse one cycle", wake_pulse, 1'b0);
    endtask

    task automatic t_run_snoop();
        enter_quiet_nap();
        check("R3", "napping clk_en", core_clk_en, 1'b0);
        run_req = 1'b1;
        step(2);
        check("R4", "clk_en before 3rd edge", core_clk_en, 1'b0);
        step(1);
        check("R4", "clk_en after 3rd edge", core_clk_en, 1'b1);
        check("R4", "dispatch_stop held", dispatch_stop, 1'b1);
        check("R4", "msr_pow held", msr_pow, 1'b1);
        bus_busy = 3'b001;
        step(1);
        check("R5", "halted drops on activity", halted, 1'b0);
        run_req = 1'b0;
        step(4);
        check("R6", "clk stays while not halted", core_clk_en, 1'b1);
        bus_busy = 3'b000;
        step(1);
        check("R5", "halted returns", halted, 1'b1);
        check("R6", "clk one more cycle", core_clk_en, 1'b1);
        step(1);
        check("R6", "clk removed", core_clk_en, 1'b0);
        check("R6", "halted kept", halted, 1'b1);
        wake_up();
    endtask

    task automatic t_no_ee();
        ee_enable = 1'b0;
        enter_quiet_nap();
        wake_src = 2'b11;
        step(3);
        check("R8", "clk_en", core_clk_en, 1'b0);
        check("R8", "halted", halted, 1'b1);
        check("R8", "wake_pulse", wake_pulse, 1'b0);
        ee_enable = 1'b1;
        step(1);
        wake_src = 2'b00;
        check("R7", "wake after enable", wake_pulse, 1'b1);
        step(1);
    endtask

    task automatic t_wake_vs_run();
        enter_quiet_nap();
        ee_enable = 1'b1;
        wake_src  = 2'b01;
        run_req   = 1'b1;
        step(1);
        wake_src  = 2'b00;
        check("R9", "wake_pulse", wake_pulse, 1'b1);
        check("R9", "dispatch_stop", dispatch_stop, 1'b0);
        check("R9", "halted", halted, 1'b0);
        step(3);
        check("R9", "dispatch after lingering run", dispatch_stop, 1'b0);
        check("R9", "clk_en", core_clk_en, 1'b1);
        run_req = 1'b0;
        step(3);
    endtask

    task automatic t_drain_wake();
        core_busy = 1'b1;
        pow_set   = 1'b1;
        step(1);
        pow_set   = 1'b0;
        ee_enable = 1'b1;
        wake_src  = 2'b10;
        step(2);
        check("R10", "no wake while busy", wake_pulse, 1'b0);
        check("R10", "msr_pow held", msr_pow, 1'b1);
        check("R10", "clk_en held", core_clk_en, 1'b1);
        core_busy = 1'b0;
        step(1);
        wake_src  = 2'b00;
        check("R10", "wake_pulse at quiet", wake_pulse, 1'b1);
        check("R10", "msr_pow cleared", msr_pow, 1'b0);
        check("R10", "dispatch_stop cleared", dispatch_stop, 1'b0);
        check("R10", "clk_en", core_clk_en, 1'b1);
        step(1);
    endtask

    task automatic t_drain_into_run();
        run_req = 1'b1;
        step(3);
        enter_quiet_nap();
        check("R11", "clk_en", core_clk_en, 1'b1);
        check("R11", "halted", halted, 1'b1);
        check("R11", "dispatch_stop", dispatch_stop, 1'b1);
        run_req = 1'b0;
        step(3);
        check("R6", "clk off after run falls", core_clk_en, 1'b0);
        wake_up();
    endtask

    task automatic t_active_irq();
        ee_enable = 1'b1;
        wake_src  = 2'b11;
        step(2);
        check("R12", "wake_pulse while running", wake_pulse, 1'b0);
        check("R12", "dispatch_stop while running", dispatch_stop, 1'b0);
        wake_src  = 2'b00;
        step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_entry_busy();
        t_run_snoop();
        t_no_ee();
        t_wake_vs_run();
        t_drain_wake();
        t_drain_into_run();
        t_active_irq();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule